// File: doc/BRIEF.md
# Calendar RTC register bank

This block is the register front end of a real-time clock. It keeps a packed date word, a packed time word, a control word that carries two update-pending flags, and a small set of scratch registers. Software reaches it through a 32-bit word register port with an address, a write strobe with data, and a read strobe with combinational read data. A write to the date or the time word raises the matching pending flag. Reading the control word returns the flags and clears them in the same access, so software can tell that an update has landed since it last looked.

A one-cycle `tick` pulse advances the time by one second. The carry runs through minutes, hours and the day of the week, and then into the date word with month lengths and leap years. The parameter `LAYOUT` chooses one of two address maps. `BASE_YEAR` is the year that the year field counts from. Two preset parameters give the reset values of the date and time words.

Top module: `rtcb_regbank`

## Requirements
- R1: After reset, the control word reads 0, every scratch register reads 0, the date word reads `PRESET_DATE` and the time word reads `PRESET_TIME`.
- R2: A write to the date word stores the data and sets control bit 7. A write to the time word stores the data and sets control bit 8.
- R3: A read of the control word returns the current flags (bit 7 date, bit 8 time, all other bits 0) and clears both flags at the end of that access. Writes to the control word have no effect.
- R4: The scratch registers are plain read/write words. Layout 0 has 4 of them at 0x20, 0x24, 0x28 and 0x2C. Layout 1 has 8 of them at 0x100 to 0x11C, 4 bytes apart.
- R5: Layout 0 places control at 0x00, date at 0x04 and time at 0x08. Layout 1 places control at 0x00, date at 0x10 and time at 0x14. An offset that only the other layout maps is unmapped.
- R6: An unmapped offset, or one whose two low bits are not 00, reads as 0 and ignores writes. `rd_data` is 0 while `rd_en` is low.
- R7: Time word fields are: second in bits 5:0, minute in bits 13:8, hour in bits 20:16, weekday in bits 31:29. On a tick, a second of 59 wraps to 0 and carries into the minute. A minute of 59 wraps to 0 and carries into the hour. An hour of 23 wraps to 0 and advances the day.
- R8: Each day advance increments the weekday, and 6 wraps to 0.
- R9: Date word fields are: day in bits 7:0, month (1 to 12) in bits 15:8, year offset in bits 31:16. The day wraps to 1 after the month's last day: 30 for months 4, 6, 9 and 11; 28 or 29 for month 2; 31 otherwise. February has 29 days when the year offset plus `BASE_YEAR` is divisible by 4. Month 12 wraps to 1 and increments the year offset.
- R10: A bus write to the time or date word in the same cycle as a tick stores the written value in that word, not the ticked value. The word that is not written still follows the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | ADDR_W | Byte offset of the access |
| wr_en | input | 1 | Write strobe for one word |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; a control-word read clears the flags |
| rd_data | output | 32 | Combinational read data, 0 when idle or unmapped |
| tick | input | 1 | One-cycle pulse that advances the time by one second |

## Verification
The calendar is swept over every month of four consecutive year offsets. Each case starts from the month's last day at 23:59:59, so one tick must carry through every field. This separates the 28, 29, 30 and 31 day lengths, the December year carry and the weekday wrap. A long run of 3661 ticks from midnight exercises the second and minute carries alone, away from any day boundary. The register-map patterns write to the offsets of both layouts on both configurations, and to misaligned offsets. A date that changes, or a flag that rises, exposes a decode that leaks into the other map. Writes that coincide with a tick show whether the bus value wins in the written word while the other word still advances.

// File: rtl/rtcb_pkg.sv
package rtcb_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_DATE,
    SEL_TIME,
    SEL_GP
  } sel_e;

  localparam int DATA_W        = 32;
  localparam int FLAG_DATE_BIT = 7;
  localparam int FLAG_TIME_BIT = 8;

  // Length of a month; out-of-range month codes fall back to 31 days.
  function automatic logic [7:0] month_len(input logic [7:0] month, input logic leap);
    logic [7:0] len;
    case (month)
      8'd2:                     len = leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:  len = 8'd30;
      default:                  len = 8'd31;
    endcase
    return len;
  endfunction

endpackage

// File: rtl/rtcb_decode.sv
module rtcb_decode
  import rtcb_pkg::*;
#(
  parameter int LAYOUT   = 0,
  parameter int ADDR_W   = 10,
  parameter int NUM_GP   = 4,
  parameter int GP_IDX_W = 2
) (
  input  logic [ADDR_W-1:0]   addr,
  output sel_e                sel,
  output logic [GP_IDX_W-1:0] gp_idx
);

  localparam logic [ADDR_W-1:0] OFS_CTRL   = '0;
  localparam logic [ADDR_W-1:0] OFS_DATE   = (LAYOUT == 0) ? ADDR_W'(4)  : ADDR_W'(16);
  localparam logic [ADDR_W-1:0] OFS_TIME   = (LAYOUT == 0) ? ADDR_W'(8)  : ADDR_W'(20);
  localparam int                GP_BASE    = (LAYOUT == 0) ? 32 : 256;
  localparam logic [ADDR_W-1:0] OFS_GP     = ADDR_W'(GP_BASE);
  localparam logic [ADDR_W-1:0] OFS_GP_END = ADDR_W'(GP_BASE + 4 * NUM_GP);

  logic [ADDR_W-1:0] gp_ofs;

  always_comb begin
    sel    = SEL_NONE;
    gp_ofs = addr - OFS_GP;
    gp_idx = GP_IDX_W'(gp_ofs >> 2);
    if (addr[1:0] == 2'b00) begin
      if (addr == OFS_CTRL)                          sel = SEL_CTRL;
      else if (addr == OFS_DATE)                     sel = SEL_DATE;
      else if (addr == OFS_TIME)                     sel = SEL_TIME;
      else if (addr >= OFS_GP && addr < OFS_GP_END)  sel = SEL_GP;
    end
  end

endmodule

// File: rtl/rtcb_calendar.sv
module rtcb_calendar
  import rtcb_pkg::*;
#(
  parameter int BASE_YEAR = 2000
) (
  input  logic              tick,
  input  logic [DATA_W-1:0] time_q,
  input  logic [DATA_W-1:0] date_q,
  output logic [DATA_W-1:0] time_nx,
  output logic [DATA_W-1:0] date_nx
);

  localparam logic [1:0] YR_MOD = 2'(BASE_YEAR % 4);

  logic [5:0]  sec, mins;
  logic [4:0]  hr;
  logic [2:0]  wday;
  logic [7:0]  day, mon, mlen;
  logic [15:0] yr;
  logic [1:0]  ysum;
  logic        sec_wrap, min_wrap, hr_wrap, day_wrap, mon_wrap;

  always_comb begin
    sec  = time_q[5:0];
    mins = time_q[13:8];
    hr   = time_q[20:16];
    wday = time_q[31:29];
    day  = date_q[7:0];
    mon  = date_q[15:8];
    yr   = date_q[31:16];
    ysum = yr[1:0] + YR_MOD;
    mlen = month_len(mon, ysum == 2'b00);

    sec_wrap = sec >= 6'd59;
    min_wrap = sec_wrap && (mins >= 6'd59);
    hr_wrap  = min_wrap && (hr >= 5'd23);
    day_wrap = hr_wrap && (day >= mlen);
    mon_wrap = day_wrap && (mon >= 8'd12);

    time_nx = time_q;
    date_nx = date_q;
    if (tick) begin
      time_nx[5:0] = sec_wrap ? 6'd0 : sec + 6'd1;
      if (sec_wrap) time_nx[13:8]  = min_wrap ? 6'd0 : mins + 6'd1;
      if (min_wrap) time_nx[20:16] = hr_wrap ? 5'd0 : hr + 5'd1;
      if (hr_wrap) begin
        time_nx[31:29] = (wday >= 3'd6) ? 3'd0 : wday + 3'd1;
        date_nx[7:0]   = day_wrap ? 8'd1 : day + 8'd1;
      end
      if (day_wrap) date_nx[15:8]  = mon_wrap ? 8'd1 : mon + 8'd1;
      if (mon_wrap) date_nx[31:16] = yr + 16'd1;
    end
  end

endmodule

// File: rtl/rtcb_scratch.sv
module rtcb_scratch
  import rtcb_pkg::*;
#(
  parameter int NUM_GP   = 4,
  parameter int GP_IDX_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [GP_IDX_W-1:0] idx,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   rd_data
);

  logic [DATA_W-1:0] bank [NUM_GP];

  for (genvar g = 0; g < NUM_GP; g++) begin : g_word
    logic [DATA_W-1:0] word_q;
    logic              word_ce;

    assign word_ce = wr_en && (idx == GP_IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (word_ce) word_q <= wr_data;
    end

    assign bank[g] = word_q;
  end

  assign rd_data = bank[idx];

  // R4: without a write, a word held at a steady index reads back unchanged
  a_r4_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en ##1 $stable(idx) |-> $stable(rd_data));

endmodule

// File: rtl/rtcb_regbank.sv
module rtcb_regbank
  import rtcb_pkg::*;
#(
  parameter int          LAYOUT      = 0,
  parameter int          ADDR_W      = 10,
  parameter int          BASE_YEAR   = 2000,
  parameter logic [31:0] PRESET_DATE = 32'h0000_0101,
  parameter logic [31:0] PRESET_TIME = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  output logic [31:0]       rd_data,
  input  logic              tick
);

  localparam int NUM_GP   = (LAYOUT == 0) ? 4 : 8;
  localparam int GP_IDX_W = $clog2(NUM_GP);

  // Reset: asserted asynchronously, released after two clock edges
  logic rs_meta, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rs_n, rs_meta} <= 2'b00;
    else        {rs_n, rs_meta} <= {rs_meta, 1'b1};
  end

  sel_e                sel;
  logic [GP_IDX_W-1:0] gp_idx;

  rtcb_decode #(
    .LAYOUT(LAYOUT), .ADDR_W(ADDR_W), .NUM_GP(NUM_GP), .GP_IDX_W(GP_IDX_W)
  ) u_decode (
    .addr(addr), .sel(sel), .gp_idx(gp_idx)
  );

  logic wr_date, wr_time, wr_gp, rd_ctrl;
  assign wr_date = wr_en && (sel == SEL_DATE);
  assign wr_time = wr_en && (sel == SEL_TIME);
  assign wr_gp   = wr_en && (sel == SEL_GP);
  assign rd_ctrl = rd_en && (sel == SEL_CTRL);

  logic [DATA_W-1:0] date_q, time_q, date_d, time_d, cal_date, cal_time;
  logic              flag_date_q, flag_time_q, flag_date_d, flag_time_d;

  rtcb_calendar #(.BASE_YEAR(BASE_YEAR)) u_calendar (
    .tick(tick), .time_q(time_q), .date_q(date_q),
    .time_nx(cal_time), .date_nx(cal_date)
  );

  logic [DATA_W-1:0] gp_rdata;
  rtcb_scratch #(.NUM_GP(NUM_GP), .GP_IDX_W(GP_IDX_W)) u_scratch (
    .clk(clk), .rst_n(rs_n), .wr_en(wr_gp), .idx(gp_idx),
    .wr_data(wr_data), .rd_data(gp_rdata)
  );

  // Next state: a bus write outranks the tick for the word it targets
  always_comb begin
    date_d      = wr_date ? wr_data : cal_date;
    time_d      = wr_time ? wr_data : cal_time;
    flag_date_d = flag_date_q;
    flag_time_d = flag_time_q;
    if (rd_ctrl) begin
      flag_date_d = 1'b0;
      flag_time_d = 1'b0;
    end
    if (wr_date) flag_date_d = 1'b1;
    if (wr_time) flag_time_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      date_q      <= PRESET_DATE;
      time_q      <= PRESET_TIME;
      flag_date_q <= 1'b0;
      flag_time_q <= 1'b0;
    end else begin
      date_q      <= date_d;
      time_q      <= time_d;
      flag_date_q <= flag_date_d;
      flag_time_q <= flag_time_d;
    end
  end

  logic [DATA_W-1:0] ctrl_word, rd_mux;
  always_comb begin
    ctrl_word                = '0;
    ctrl_word[FLAG_DATE_BIT] = flag_date_q;
    ctrl_word[FLAG_TIME_BIT] = flag_time_q;
    case (sel)
      SEL_CTRL: rd_mux = ctrl_word;
      SEL_DATE: rd_mux = date_q;
      SEL_TIME: rd_mux = time_q;
      SEL_GP:   rd_mux = gp_rdata;
      default:  rd_mux = '0;
    endcase
    rd_data = rd_en ? rd_mux : '0;
  end

  // R2: date and time writes land and raise their own flag
  a_r2_date_write_flags: assert property (@(posedge clk) disable iff (!rs_n)
    wr_date |=> (flag_date_q && date_q == $past(wr_data)));
  a_r2_time_write_flags: assert property (@(posedge clk) disable iff (!rs_n)
    wr_time |=> (flag_time_q && time_q == $past(wr_data)));
  // R3: a control read leaves both flags low afterwards
  a_r3_read_clears_flags: assert property (@(posedge clk) disable iff (!rs_n)
    rd_ctrl |=> (!flag_date_q && !flag_time_q));
  // R3: flags move only on a date/time write or a control read
  a_r3_flags_hold: assert property (@(posedge clk) disable iff (!rs_n)
    !(wr_date || wr_time || rd_ctrl) |=> $stable({flag_date_q, flag_time_q}));
  // R6: idle or unmapped accesses read zero
  a_r6_unmapped_zero: assert property (@(posedge clk) disable iff (!rs_n)
    (!rd_en || sel == SEL_NONE) |-> (rd_data == '0));
  // R7: a tick below the seconds wrap adds exactly one second
  a_r7_second_step: assert property (@(posedge clk) disable iff (!rs_n)
    (tick && !wr_time && time_q[5:0] < 6'd59) |=>
      (time_q[5:0] == $past(time_q[5:0]) + 6'd1));
  // R10: the written time wins over a coincident tick
  a_r10_write_beats_tick: assert property (@(posedge clk) disable iff (!rs_n)
    (tick && wr_time) |=> (time_q == $past(wr_data)));

endmodule

// File: tb/rtcb_regbank_test.sv
`timescale 1ns/1ps
module rtcb_regbank_test;

  localparam logic [31:0] PD_B = 32'h0018_0301;
  localparam logic [31:0] PT_B = 32'h4017_2A05;
  localparam logic [31:0] PD_A = 32'h0003_0228;
  localparam logic [31:0] PT_A = 32'h0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wen_a = 1'b0, wen_b = 1'b0, ren_a = 1'b0, ren_b = 1'b0;
  logic        tick = 1'b0;
  logic [31:0] rdata_a, rdata_b;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtcb_regbank #(.LAYOUT(1), .ADDR_W(10), .BASE_YEAR(2000),
                 .PRESET_DATE(PD_B), .PRESET_TIME(PT_B)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wen_b), .wr_data(wdata),
    .rd_en(ren_b), .rd_data(rdata_b), .tick(tick));

  rtcb_regbank #(.LAYOUT(0), .ADDR_W(10), .BASE_YEAR(2001),
                 .PRESET_DATE(PD_A), .PRESET_TIME(PT_A)) uut_a (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wen_a), .wr_data(wdata),
    .rd_en(ren_a), .rd_data(rdata_a), .tick(tick));

  function automatic logic [31:0] mk_time(int w, int h, int m, int s);
    return 32'((w << 29) | (h << 16) | (m << 8) | s);
  endfunction
  function automatic logic [31:0] mk_date(int y, int m, int d);
    return 32'((y << 16) | (m << 8) | d);
  endfunction
  function automatic int mdays(int m, int y, int base);
    if (m == 2) return (((y + base) % 4) == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input bit ia, input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wen_a = ia; wen_b = !ia;
    @(negedge clk);
    wen_a = 1'b0; wen_b = 1'b0;
  endtask

  task automatic rd(input bit ia, input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; ren_a = ia; ren_b = !ia;
    #1;
    d = ia ? rdata_a : rdata_b;
    @(negedge clk);
    ren_a = 1'b0; ren_b = 1'b0;
  endtask

  task automatic do_tick(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  initial begin
    #(5ns * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state on both layouts
    rd(0, 10'h000, v); check("R1 ctrl B", v, 32'h0);
    rd(0, 10'h010, v); check("R1 date B", v, PD_B);
    rd(0, 10'h014, v); check("R1 time B", v, PT_B);
    for (int i = 0; i < 8; i++) begin
      rd(0, 10'(256 + 4 * i), v); check("R1 gp B", v, 32'h0);
    end
    rd(1, 10'h000, v); check("R1 ctrl A", v, 32'h0);
    rd(1, 10'h004, v); check("R1 date A", v, PD_A);
    rd(1, 10'h008, v); check("R1 time A", v, PT_A);
    for (int i = 0; i < 4; i++) begin
      rd(1, 10'(32 + 4 * i), v); check("R1 gp A", v, 32'h0);
    end

    // R2 / R3: flags set by writes, cleared by a control read
    wr(0, 10'h010, 32'h0007_0B0E);
    rd(0, 10'h010, v); check("R2 date stored", v, 32'h0007_0B0E);
    rd(0, 10'h000, v); check("R2 date flag bit7", v, 32'h0000_0080);
    rd(0, 10'h000, v); check("R3 flags cleared", v, 32'h0);
    wr(0, 10'h014, 32'h2005_0607);
    rd(0, 10'h014, v); check("R2 time stored", v, 32'h2005_0607);
    rd(0, 10'h000, v); check("R2 time flag bit8", v, 32'h0000_0100);
    wr(1, 10'h004, 32'h0001_0203);
    wr(1, 10'h008, 32'h0001_0203);
    rd(1, 10'h000, v); check("R2 both flags A", v, 32'h0000_0180);
    rd(1, 10'h000, v); check("R3 cleared A", v, 32'h0);
    wr(0, 10'h000, 32'hFFFF_FFFF);
    rd(0, 10'h000, v); check("R3 ctrl write ignored", v, 32'h0);

    // R4: scratch storage
    for (int i = 0; i < 8; i++) wr(0, 10'(256 + 4 * i), 32'hA5A5_0000 + 32'(i * 17));
    for (int i = 0; i < 8; i++) begin
      rd(0, 10'(256 + 4 * i), v); check("R4 gp B", v, 32'hA5A5_0000 + 32'(i * 17));
    end
    for (int i = 0; i < 4; i++) wr(1, 10'(32 + 4 * i), ~32'(i * 3 + 1));
    for (int i = 0; i < 4; i++) begin
      rd(1, 10'(32 + 4 * i), v); check("R4 gp A", v, ~32'(i * 3 + 1));
    end

    // R5: offsets of the other layout are unmapped
    wr(0, 10'h004, 32'h1234_5678);
    wr(0, 10'h020, 32'h1234_5678);
    rd(0, 10'h004, v); check("R5 B 0x04 unmapped", v, 32'h0);
    rd(0, 10'h020, v); check("R5 B 0x20 unmapped", v, 32'h0);
    rd(0, 10'h010, v); check("R5 B date untouched", v, 32'h0007_0B0E);
    rd(0, 10'h000, v); check("R5 B no flag", v, 32'h0);
    wr(1, 10'h010, 32'h1111_2222);
    wr(1, 10'h100, 32'h3333_4444);
    rd(1, 10'h010, v); check("R5 A 0x10 unmapped", v, 32'h0);
    rd(1, 10'h100, v); check("R5 A 0x100 unmapped", v, 32'h0);
    rd(1, 10'h004, v); check("R5 A date untouched", v, 32'h0001_0203);
    rd(1, 10'h000, v); check("R5 A no flag", v, 32'h0);

    // R6: misaligned, unmapped, idle
    wr(0, 10'h011, 32'hDEAD_BEEF);
    wr(0, 10'h3FC, 32'hDEAD_BEEF);
    rd(0, 10'h010, v); check("R6 misaligned write ignored", v, 32'h0007_0B0E);
    rd(0, 10'h012, v); check("R6 misaligned read zero", v, 32'h0);
    rd(0, 10'h3FC, v); check("R6 unmapped read zero", v, 32'h0);
    rd(0, 10'h000, v); check("R6 no flag", v, 32'h0);
    @(negedge clk); addr = 10'h010; #1;
    check("R6 idle read zero", rdata_b, 32'h0);

    // R7: carries within a day
    wr(0, 10'h014, mk_time(3, 0, 0, 0));
    do_tick(3661);
    rd(0, 10'h014, v); check("R7 3661 ticks", v, mk_time(3, 1, 1, 1));
    wr(0, 10'h014, mk_time(4, 10, 59, 58));
    do_tick(2);
    rd(0, 10'h014, v); check("R7 minute-hour carry", v, mk_time(4, 11, 0, 0));

    // R8 / R9: end-of-month sweep over four year offsets, base 2000
    for (int y = 0; y < 4; y++) begin
      for (int m = 1; m <= 12; m++) begin
        int ld, w, em, ey;
        ld = mdays(m, y, 2000);
        w  = (m + y) % 7;
        em = (m == 12) ? 1 : m + 1;
        ey = (m == 12) ? y + 1 : y;
        wr(0, 10'h010, mk_date(y, m, ld));
        wr(0, 10'h014, mk_time(w, 23, 59, 59));
        do_tick(1);
        rd(0, 10'h010, v); check("R9 month rollover", v, mk_date(ey, em, 1));
        rd(0, 10'h014, v); check("R8 weekday advance", v, mk_time((w == 6) ? 0 : w + 1, 0, 0, 0));
        wr(0, 10'h010, mk_date(y, m, ld - 1));
        wr(0, 10'h014, mk_time(w, 23, 59, 59));
        do_tick(1);
        rd(0, 10'h010, v); check("R9 day step", v, mk_date(y, m, ld));
      end
    end

    // R9: leap rule follows the base year (2001 on layout 0)
    wr(1, 10'h004, mk_date(3, 2, 28));
    wr(1, 10'h008, mk_time(6, 23, 59, 59));
    do_tick(1);
    rd(1, 10'h004, v); check("R9 leap 2004", v, mk_date(3, 2, 29));
    rd(1, 10'h008, v); check("R8 weekday wrap A", v, mk_time(0, 0, 0, 0));
    wr(1, 10'h004, mk_date(0, 2, 28));
    wr(1, 10'h008, mk_time(1, 23, 59, 59));
    do_tick(1);
    rd(1, 10'h004, v); check("R9 non-leap 2001", v, mk_date(0, 3, 1));

    // R10: bus write beats a coincident tick
    @(negedge clk);
    addr = 10'h014; wdata = mk_time(5, 12, 30, 20); wen_b = 1'b1; tick = 1'b1;
    @(negedge clk);
    wen_b = 1'b0; tick = 1'b0;
    rd(0, 10'h014, v); check("R10 time write wins", v, mk_time(5, 12, 30, 20));
    wr(0, 10'h014, mk_time(3, 23, 59, 59));
    @(negedge clk);
    addr = 10'h010; wdata = mk_date(9, 5, 31); wen_b = 1'b1; tick = 1'b1;
    @(negedge clk);
    wen_b = 1'b0; tick = 1'b0;
    rd(0, 10'h010, v); check("R10 date write wins", v, mk_date(9, 5, 31));
    rd(0, 10'h014, v); check("R10 time still ticks", v, mk_time(4, 0, 0, 0));

    summary();
    $finish;
  end

endmodule